// File: doc/BRIEF.md
# Counter Clock and Gate Router

This block sits beside a bank of three counter channels and decides, for each channel, when the counter advances and whether it is allowed to count. A chain of divide-by-ten stages turns a reference tick (one single-cycle pulse per period of a 10 MHz reference) into pulses at 1 MHz, 100 kHz, 10 kHz and 1 kHz. A per-channel clock selector picks one of these rates, a neighbouring counter's output, or an external clock line. It emits a single-cycle count enable on each rising edge of the chosen source. A per-channel gate selector holds the counter's gate high or low, passes an external gate line, or passes the inverted output of another channel.

The selectors are set through two byte-wide configuration writes, one for clock sources and one for gate sources. Each byte carries both the channel number and the source code. The counters are not part of the block: their outputs come back in as inputs. This lets channels be chained in a fixed ring, so that one counter's output clocks or gates a neighbour.

Top module: `cnt_clk_gate_router`

## Requirements
- R1: A configuration byte takes the target channel from bits [4:3] and the source code from bits [2:0], and bits [7:5] have no effect. A clock write (cfg_clk_we) changes only a clock selection. A gate write (cfg_gate_we) changes only a gate selection.
- R2: After reset every channel uses clock code 1 and gate code 0, so cnt_gate is all ones and cnt_clk_en follows rising edges of ref_tick.
- R3: A write whose channel field is 3 changes no selection on any channel.
- R4: Clock code 1 selects ref_tick, and cnt_clk_en is high in the same cycle as a ref_tick rising edge.
- R5: Clock codes 2, 3, 4 and 5 select pulses that coincide with every 10th, 100th, 1000th and 10000th ref_tick cycle counted since reset.
- R6: Clock code 6 selects the previous channel's counter output: channel 0 takes cnt_out[2], channel 1 takes cnt_out[0], and channel 2 takes cnt_out[1]. A rising edge gives one enable cycle.
- R7: Clock code 7 selects ext_clk of the same channel, and each rising edge gives one enable cycle.
- R8: Clock code 0 is reserved and never produces an enable.
- R9: An enable lasts exactly one cycle. A source that stays high gives an enable only in its first high cycle, and two consecutive cycles never both carry an enable on one channel.
- R10: Gate code 0 drives cnt_gate high, code 1 drives it low, code 2 passes ext_gate of the same channel, and codes 4 to 7 drive it low.
- R11: Gate code 3 passes the inverted counter output of the next channel: channel 0 takes cnt_out[1], channel 1 takes cnt_out[2], and channel 2 takes cnt_out[0].
- R12: A selection written at one clock edge governs the outputs from the cycle that follows that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ref_tick | input | 1 | Reference tick, one pulse per reference period |
| cfg_clk_we | input | 1 | Write strobe for a clock source selection |
| cfg_gate_we | input | 1 | Write strobe for a gate source selection |
| cfg_wdata | input | 8 | Configuration byte (channel in [4:3], code in [2:0]) |
| cnt_out | input | 3 | Output of each counter channel |
| ext_clk | input | 3 | External clock line per channel |
| ext_gate | input | 3 | External gate line per channel |
| cnt_clk_en | output | 3 | Single-cycle count enable per channel |
| cnt_gate | output | 3 | Gate level per channel |

## Verification
If a selection register held the wrong code, the effect would reach the ports in the first cycle after the write. Either the gate level would differ at once, or enables would line up with the wrong source's edges as soon as that source next rises. A prescaler stage that lost count would show up as enables that shift away from the 10th, 100th, 1000th or 10000th tick. The shift would be visible only when the affected rate next pulses, which for the slowest stage is about ten thousand ticks later. A stale edge-detect register would show up as a doubled enable, or a missing one, on a source that stays high.

// File: rtl/ccr_pkg.sv
package ccr_pkg;
   localparam int SRC_W    = 3;
   localparam int CHAN_W   = 2;
   localparam int CHAN_LSB = 3;

   typedef logic [SRC_W-1:0] src_code_t;

   // clock source codes
   localparam src_code_t CLK_RESERVED  = 3'd0;
   localparam src_code_t CLK_REF       = 3'd1;
   localparam src_code_t CLK_NEIGHBOUR = 3'd6;
   localparam src_code_t CLK_EXTERNAL  = 3'd7;

   // gate source codes
   localparam src_code_t GATE_ON        = 3'd0;
   localparam src_code_t GATE_OFF       = 3'd1;
   localparam src_code_t GATE_EXTERNAL  = 3'd2;
   localparam src_code_t GATE_NEIGHBOUR = 3'd3;
endpackage

// File: rtl/ccr_prescaler.sv
module ccr_prescaler #(
   parameter int DIV         = 10,
   parameter int NUM_DECADES = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 ref_tick,
   output logic [NUM_DECADES:0] tick
);
   localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

   assign tick[0] = ref_tick;

   for (genvar k = 0; k < NUM_DECADES; k++) begin : g_stage
      logic [CW-1:0] cnt_q;
      logic          wrap;

      assign wrap      = (cnt_q == CW'(DIV - 1));
      assign tick[k+1] = tick[k] & wrap;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            cnt_q <= '0;
         else if (tick[k])
            cnt_q <= wrap ? '0 : cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/ccr_cfg_regs.sv
module ccr_cfg_regs
   import ccr_pkg::*;
#(
   parameter int        NUM_CH     = 3,
   parameter src_code_t RESET_CODE = 3'd0
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         we,
   input  logic [7:0]                   wdata,
   output logic [NUM_CH-1:0][SRC_W-1:0] sel
);
   logic [CHAN_W-1:0] tgt;
   assign tgt = wdata[CHAN_LSB +: CHAN_W];

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            sel[i] <= RESET_CODE;
         else if (we && tgt == CHAN_W'(i))
            sel[i] <= wdata[SRC_W-1:0];
      end
   end
endmodule

// File: rtl/ccr_chan_route.sv
module ccr_chan_route
   import ccr_pkg::*;
#(
   parameter int NUM_DECADES = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  src_code_t            clk_sel,
   input  src_code_t            gate_sel,
   input  logic [NUM_DECADES:0] tick,
   input  logic                 nb_clk,
   input  logic                 nb_gate,
   input  logic                 ext_clk,
   input  logic                 ext_gate,
   output logic                 clk_en,
   output logic                 gate
);
   logic src_now;
   logic src_prev_q;

   always_comb begin
      src_now = 1'b0;
      case (clk_sel)
         CLK_RESERVED:  src_now = 1'b0;
         CLK_NEIGHBOUR: src_now = nb_clk;
         CLK_EXTERNAL:  src_now = ext_clk;
         default: begin
            for (int k = 0; k <= NUM_DECADES; k++)
               if (clk_sel == SRC_W'(k + 1)) src_now = tick[k];
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) src_prev_q <= 1'b0;
      else        src_prev_q <= src_now;
   end

   assign clk_en = src_now & ~src_prev_q;

   always_comb begin
      case (gate_sel)
         GATE_ON:        gate = 1'b1;
         GATE_OFF:       gate = 1'b0;
         GATE_EXTERNAL:  gate = ext_gate;
         GATE_NEIGHBOUR: gate = ~nb_gate;
         default:        gate = 1'b0;
      endcase
   end
endmodule

// File: rtl/cnt_clk_gate_router.sv
module cnt_clk_gate_router
   import ccr_pkg::*;
#(
   parameter int NUM_CH      = 3,
   parameter int DIV         = 10,
   parameter int NUM_DECADES = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ref_tick,
   input  logic              cfg_clk_we,
   input  logic              cfg_gate_we,
   input  logic [7:0]        cfg_wdata,
   input  logic [NUM_CH-1:0] cnt_out,
   input  logic [NUM_CH-1:0] ext_clk,
   input  logic [NUM_CH-1:0] ext_gate,
   output logic [NUM_CH-1:0] cnt_clk_en,
   output logic [NUM_CH-1:0] cnt_gate
);
   if (NUM_CH < 2 || NUM_CH > (1 << CHAN_W) - 1) begin : g_bad_ch
      $error("NUM_CH must leave one channel code unused and be at least 2");
   end
   if (DIV < 2) begin : g_bad_div
      $error("DIV must be at least 2");
   end
   if (NUM_DECADES < 1 || NUM_DECADES > 4) begin : g_bad_dec
      $error("NUM_DECADES must fit clock codes 2 to 5");
   end

   logic [NUM_DECADES:0]            tick_vec;
   logic [NUM_CH-1:0][SRC_W-1:0]    clk_sel_q;
   logic [NUM_CH-1:0][SRC_W-1:0]    gate_sel_q;

   ccr_prescaler #(.DIV(DIV), .NUM_DECADES(NUM_DECADES)) u_presc (
      .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .tick(tick_vec)
   );

   ccr_cfg_regs #(.NUM_CH(NUM_CH), .RESET_CODE(CLK_REF)) u_clk_cfg (
      .clk(clk), .rst_n(rst_n), .we(cfg_clk_we), .wdata(cfg_wdata), .sel(clk_sel_q)
   );

   ccr_cfg_regs #(.NUM_CH(NUM_CH), .RESET_CODE(GATE_ON)) u_gate_cfg (
      .clk(clk), .rst_n(rst_n), .we(cfg_gate_we), .wdata(cfg_wdata), .sel(gate_sel_q)
   );

   for (genvar i = 0; i < NUM_CH; i++) begin : g_route
      localparam int PREV_CH = (i + NUM_CH - 1) % NUM_CH;
      localparam int NEXT_CH = (i + 1) % NUM_CH;

      ccr_chan_route #(.NUM_DECADES(NUM_DECADES)) u_route (
         .clk(clk), .rst_n(rst_n),
         .clk_sel(clk_sel_q[i]), .gate_sel(gate_sel_q[i]),
         .tick(tick_vec),
         .nb_clk(cnt_out[PREV_CH]), .nb_gate(cnt_out[NEXT_CH]),
         .ext_clk(ext_clk[i]), .ext_gate(ext_gate[i]),
         .clk_en(cnt_clk_en[i]), .gate(cnt_gate[i])
      );
   end
endmodule

// File: rtl/ccr_checker.sv
module ccr_checker #(
   parameter int NUM_CH      = 3,
   parameter int NUM_DECADES = 4
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   cfg_clk_we,
   input logic                   cfg_gate_we,
   input logic [7:0]             cfg_wdata,
   input logic [NUM_CH-1:0]      cnt_out,
   input logic [NUM_CH-1:0]      cnt_clk_en,
   input logic [NUM_CH-1:0]      cnt_gate,
   input logic [NUM_CH-1:0][2:0] clk_sel,
   input logic [NUM_CH-1:0][2:0] gate_sel,
   input logic [NUM_DECADES:0]   tick
);
   for (genvar k = 0; k < NUM_DECADES; k++) begin : g_dec
      p_nested_ticks_r5: assert property (@(posedge clk) disable iff (!rst_n)
         tick[k+1] |-> tick[k]);
   end

   p_ch3_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ((cfg_clk_we || cfg_gate_we) && cfg_wdata[4:3] == 2'd3)
      |=> ($stable(clk_sel) && $stable(gate_sel)));

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      localparam int PREV_CH = (i + NUM_CH - 1) % NUM_CH;
      localparam int NEXT_CH = (i + 1) % NUM_CH;

      p_clk_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
         (cfg_clk_we && cfg_wdata[4:3] == 2'(i))
         |=> (clk_sel[i] == $past(cfg_wdata[2:0])));

      p_gate_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
         (cfg_gate_we && cfg_wdata[4:3] == 2'(i))
         |=> (gate_sel[i] == $past(cfg_wdata[2:0])));

      p_no_back_to_back_r9: assert property (@(posedge clk) disable iff (!rst_n)
         cnt_clk_en[i] |=> !cnt_clk_en[i]);

      p_reserved_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
         (clk_sel[i] == 3'd0) |-> !cnt_clk_en[i]);

      p_cascade_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
         (clk_sel[i] == 3'd6 && $past(clk_sel[i]) == 3'd6 &&
          cnt_out[PREV_CH] && !$past(cnt_out[PREV_CH])) |-> cnt_clk_en[i]);

      p_gate_cascade_r11: assert property (@(posedge clk) disable iff (!rst_n)
         (gate_sel[i] == 3'd3) |-> (cnt_gate[i] == !cnt_out[NEXT_CH]));

      p_gate_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
         (gate_sel[i] == 3'd1 || gate_sel[i][2]) |-> !cnt_gate[i]);
   end
endmodule

bind cnt_clk_gate_router ccr_checker #(.NUM_CH(NUM_CH), .NUM_DECADES(NUM_DECADES)) u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_clk_we(cfg_clk_we), .cfg_gate_we(cfg_gate_we),
   .cfg_wdata(cfg_wdata), .cnt_out(cnt_out), .cnt_clk_en(cnt_clk_en),
   .cnt_gate(cnt_gate), .clk_sel(clk_sel_q), .gate_sel(gate_sel_q), .tick(tick_vec)
);

// File: tb/sim_cnt_clk_gate_router.sv
`timescale 1ns/1ps
module sim_cnt_clk_gate_router;
   localparam int NCH  = 3;
   localparam int LAST = 24000;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           ref_tick = 1'b0;
   logic           cfg_clk_we = 1'b0;
   logic           cfg_gate_we = 1'b0;
   logic [7:0]     cfg_wdata = 8'h00;
   logic [NCH-1:0] cnt_out = '0;
   logic [NCH-1:0] ext_clk = '0;
   logic [NCH-1:0] ext_gate = '0;
   logic [NCH-1:0] cnt_clk_en;
   logic [NCH-1:0] cnt_gate;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   // reference model state
   int    tick_cnt = 0;
   int    csrc [NCH];
   int    gsrc [NCH];
   bit    prev [NCH];
   string note = "";
   string pending = "";

   always #2 clk = ~clk;

   cnt_clk_gate_router u0 (
      .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick),
      .cfg_clk_we(cfg_clk_we), .cfg_gate_we(cfg_gate_we), .cfg_wdata(cfg_wdata),
      .cnt_out(cnt_out), .ext_clk(ext_clk), .ext_gate(ext_gate),
      .cnt_clk_en(cnt_clk_en), .cnt_gate(cnt_gate)
   );

   function automatic bit model_src(int ch, int code);
      int div;
      case (code)
         0: return 1'b0;
         1: return ref_tick;
         6: return cnt_out[(ch + 2) % 3];
         7: return ext_clk[ch];
         default: begin
            div = 10 ** (code - 1);
            return ref_tick && ((tick_cnt + 1) % div == 0);
         end
      endcase
   endfunction

   function automatic bit model_gate(int ch, int code);
      case (code)
         0: return 1'b1;
         1: return 1'b0;
         2: return ext_gate[ch];
         3: return !cnt_out[(ch + 1) % 3];
         default: return 1'b0;
      endcase
   endfunction

   function automatic string clk_tag(int code, bit suppressed);
      if (suppressed) return "R9";
      case (code)
         0: return "R8";
         1: return "R4";
         6: return "R6";
         7: return "R7";
         default: return "R5";
      endcase
   endfunction

   task automatic reset_model();
      tick_cnt = 0;
      for (int c = 0; c < NCH; c++) begin
         csrc[c] = 1; gsrc[c] = 0; prev[c] = 1'b0;
      end
   endtask

   task automatic model_update();
      int ch;
      if (!rst_n) begin
         reset_model();
      end else begin
         for (int c = 0; c < NCH; c++) prev[c] = model_src(c, csrc[c]);
         ch = int'(cfg_wdata[4:3]);
         if (cfg_clk_we && ch < NCH)  csrc[ch] = int'(cfg_wdata[2:0]);
         if (cfg_gate_we && ch < NCH) gsrc[ch] = int'(cfg_wdata[2:0]);
         if (ref_tick) tick_cnt++;
      end
      note = pending;
      pending = "";
   endtask

   task automatic check_bit(string req, int ch, string what, logic act, logic exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s ch%0d %s actual=%b expected=%b at %0t %s",
                  req, ch, what, act, exp, $time, note);
      end
   endtask

   task automatic compare();
      bit s, e, supp;
      for (int c = 0; c < NCH; c++) begin
         s = model_src(c, csrc[c]);
         e = s && !prev[c];
         supp = s && prev[c];
         check_bit(clk_tag(csrc[c], supp), c, {"clk_en ", note}, cnt_clk_en[c], e);
         check_bit((gsrc[c] == 3) ? "R11" : "R10", c, {"gate ", note},
                   cnt_gate[c], model_gate(c, gsrc[c]));
      end
   endtask

   task automatic write_cfg(bit is_gate, int ch, int code, string tag);
      cfg_wdata = {3'b101, 2'(ch), 3'(code)};
      if (is_gate) cfg_gate_we = 1'b1; else cfg_clk_we = 1'b1;
      pending = tag;
   endtask

   task automatic drive(int c);
      cfg_clk_we = 1'b0;
      cfg_gate_we = 1'b0;
      cfg_wdata = 8'($urandom);
      if ((c >= 10 && c < 16) || (c >= 23100 && c < 23110)) ref_tick = 1'b1;
      else ref_tick = (c % 2 == 0);
      cnt_out  = 3'($urandom);
      ext_clk  = 3'($urandom);
      ext_gate = 3'($urandom);
      case (c)
         20:    write_cfg(1'b0, 0, 7, "R1 R12");
         40:    write_cfg(1'b0, 1, 6, "R1 R12");
         41:    write_cfg(1'b0, 2, 0, "R1 R12");
         60:    write_cfg(1'b1, 0, 3, "R1 R12");
         61:    write_cfg(1'b1, 1, 2, "R1 R12");
         62:    write_cfg(1'b1, 2, 1, "R1 R12");
         80:    write_cfg(1'b1, 2, 5, "R10");
         100:   write_cfg(1'b0, 3, 0, "R3");
         101:   write_cfg(1'b1, 3, 1, "R3");
         300:   write_cfg(1'b0, 0, 2, "R5 R12");
         301:   write_cfg(1'b0, 1, 3, "R5 R12");
         302:   write_cfg(1'b0, 2, 4, "R5 R12");
         320:   write_cfg(1'b1, 2, 0, "R10");
         5000:  write_cfg(1'b0, 0, 5, "R5");
         5001:  write_cfg(1'b0, 1, 6, "R6");
         5002:  write_cfg(1'b1, 1, 3, "R11");
         23000: write_cfg(1'b0, 0, 1, "R9");
         default: ;
      endcase
   endtask

   initial begin
      reset_model();
      repeat (3) @(posedge clk);
      @(negedge clk);
      // reset state while rst_n is low (R2)
      for (int c = 0; c < NCH; c++) begin
         check_bit("R2", c, "gate in reset", cnt_gate[c], 1'b1);
         check_bit("R2", c, "clk_en in reset", cnt_clk_en[c], 1'b0);
      end
      @(posedge clk);
      model_update();
      #1 rst_n = 1'b1;
      ref_tick = 1'b0;
      pending = "R2";
      for (int c = 0; c < LAST; c++) begin
         @(posedge clk);
         model_update();
         #1;
         drive(c);
         @(negedge clk);
         compare();
      end
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #(4 * (LAST + 2000));
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule